// File: doc/BRIEF.md
# Real-Time Clock Once-Per-Second Update and Alarm Unit

This block paces the once-per-second update of a real-time clock. It divides a 32768 Hz tick enable down to one update event per second. When the clock is allowed to run, each event sends a one-cycle strobe to an external time-of-day counter. The block also drives the update-in-progress status bit during the short window before each increment. After the increment it sets an update-ended flag and compares the new hours, minutes and seconds against three alarm fields. When the alarm matches, it sets an alarm flag. It raises an interrupt flag only for flags that become newly set while their enable is on.

The divider control field can hold the divider in reset. While held, no updates happen. When the hold is released, the first update comes half a second later. The set-mode input freezes time but lets update events continue. A clear input stands for the read of the flag register, which clears all flags. The time and alarm fields use the stored register encoding: BCD or binary, and 12- or 24-hour form.

Top module: `rtc_update_alarm`

## Requirements
- R1: During and right after reset, `incTime`, `uip`, `ufFlag`, `afFlag` and `irqFlag` are all 0.
- R2: When the divider is not held, one update event occurs for every `TICKS_PER_SEC` cycles on which `tick` is 1. Cycles with `tick` at 0 do not count.
- R3: When the clock runs, `uip` is 1 exactly while the last `UIP_TICKS` ticks before an increment are pending, and it drops when that increment is issued. When the clock does not run, `uip` is 0.
- R4: `divSel[2:1] == 2'b11` holds the divider in reset: no update events and `uip` = 0. Leaving that state starts the first event after `TICKS_PER_SEC/2` ticks.
- R5: The clock runs only when `setMode` = 0 and `divSel <= 3'b010`. An update event pulses `incTime` for one cycle only when the clock runs. Otherwise the event still sets the flags, but no increment is issued.
- R6: Every update event sets `ufFlag`. The alarm is compared one cycle after `incTime`, on the already-incremented time, and `afFlag` is set on a match.
- R7: An alarm field whose bits [7:6] are `2'b11` matches any value. With all three fields in that form, `afFlag` is set on every event.
- R8: Fields are BCD unless `binMode` = 1. When `hour24` = 0, hours are 12-hour values with bit 7 as the PM marker, and they are compared as the same hour of the day.
- R9: `irqFlag` is set only by a flag that goes from 0 to 1 while its enable is 1. The enable is `uieEn` for the update flag, forced off while `setMode` = 1, and `aieEn` for the alarm flag.
- R10: A one-cycle `clrFlags` clears `ufFlag`, `afFlag` and `irqFlag`. An update in the same cycle sets its flags again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32768 Hz tick enable |
| divSel | input | 3 | Divider control field |
| setMode | input | 1 | Time-set mode, freezes time |
| uieEn | input | 1 | Update-ended interrupt enable |
| aieEn | input | 1 | Alarm interrupt enable |
| hour24 | input | 1 | 1: 24-hour form, 0: 12-hour with PM bit 7 |
| binMode | input | 1 | 1: binary fields, 0: BCD |
| curHour | input | 8 | Current hours encoding |
| curMin | input | 8 | Current minutes encoding |
| curSec | input | 8 | Current seconds encoding |
| almHour | input | 8 | Alarm hours encoding |
| almMin | input | 8 | Alarm minutes encoding |
| almSec | input | 8 | Alarm seconds encoding |
| clrFlags | input | 1 | Flag register read, clears flags |
| incTime | output | 1 | One-cycle increment strobe to the time counter |
| uip | output | 1 | Update-in-progress status |
| ufFlag | output | 1 | Update-ended flag |
| afFlag | output | 1 | Alarm flag |
| irqFlag | output | 1 | Interrupt request flag |

## Verification
The hardest situation to reach is the first update after the divider hold is released. Its timing depends on the counter having been parked at mid-second, which the ports never show directly. The bench holds the divider and watches that no flag or strobe appears. It then releases the hold on a known cycle and expects the event exactly half a second of ticks later. The "newly set" interrupt rule is also hard to observe. The bench reaches it by leaving the update flag set across an event while the enable turns on, and then requires that no interrupt appears.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  typedef struct packed {
    logic incTime;     // request one-second increment
    logic evalUpdate;  // time has been incremented, evaluate flags
  } updStrobe_t;

  function automatic logic [6:0] fieldValue(input logic [7:0] raw, input logic binMode);
    logic [6:0] v;
    if (binMode) v = raw[6:0];
    else         v = 7'(raw[6:4]) * 7'd10 + 7'(raw[3:0]);
    return v;
  endfunction

  function automatic logic [6:0] hourValue(input logic [7:0] raw, input logic binMode,
                                           input logic hour24);
    logic [6:0] v;
    v = fieldValue({1'b0, raw[6:0]}, binMode);
    if (!hour24) v = (v % 7'd12) + (raw[7] ? 7'd12 : 7'd0);
    return v;
  endfunction

  function automatic logic isWild(input logic [7:0] raw);
    return raw[7:6] == 2'b11;
  endfunction

endpackage

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [2:0] divSel,
  input  logic       setMode,
  output updStrobe_t strobe,
  output logic       uip
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] CNT_HALF  = CNT_W'(TICKS_PER_SEC / 2);
  localparam logic [CNT_W-1:0] UIP_FIRST = CNT_W'(TICKS_PER_SEC - UIP_TICKS);

  logic [CNT_W-1:0] tickCnt;
  logic             evtPhase;
  logic             divHeld;
  logic             running;

  assign divHeld = (divSel[2:1] == 2'b11);
  assign running = !setMode && (divSel <= 3'b010);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt  <= '0;
      evtPhase <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe.incTime    <= 1'b0;
      strobe.evalUpdate <= evtPhase;
      evtPhase          <= 1'b0;
      if (divHeld) begin
        tickCnt <= CNT_HALF;          // release starts mid-second
      end else if (tick) begin
        if (tickCnt == CNT_TOP) begin
          tickCnt        <= '0;
          evtPhase       <= 1'b1;
          strobe.incTime <= running;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  assign uip = running && (tickCnt >= UIP_FIRST);

  AST_NO_INC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(divHeld) |-> !strobe.incTime); // R4

  AST_EVAL_AFTER_INC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incTime |=> strobe.evalUpdate); // R6

  AST_UIP_BEFORE_INC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incTime |-> $past(uip)); // R3

  AST_NO_INC_SET: assert property (@(posedge clk) disable iff (!rstN)
    $past(setMode) |-> !strobe.incTime); // R5

endmodule

// File: rtl/rtc_upd_dpath.sv
module rtc_upd_dpath
  import rtc_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  updStrobe_t strobe,
  input  logic       clrFlags,
  input  logic       setMode,
  input  logic       uieEn,
  input  logic       aieEn,
  input  logic       hour24,
  input  logic       binMode,
  input  logic [7:0] curHour,
  input  logic [7:0] curMin,
  input  logic [7:0] curSec,
  input  logic [7:0] almHour,
  input  logic [7:0] almMin,
  input  logic [7:0] almSec,
  output logic       ufFlag,
  output logic       afFlag,
  output logic       irqFlag
);
  logic secHit, minHit, hourHit, almMatch;
  logic uieEff;
  logic baseUf, baseAf, baseIrq;
  logic newUf, newAf;

  assign secHit  = isWild(almSec) ||
                   (fieldValue(almSec, binMode) == fieldValue(curSec, binMode));
  assign minHit  = isWild(almMin) ||
                   (fieldValue(almMin, binMode) == fieldValue(curMin, binMode));
  assign hourHit = isWild(almHour) ||
                   (hourValue(almHour, binMode, hour24) == hourValue(curHour, binMode, hour24));
  assign almMatch = secHit && minHit && hourHit;

  assign uieEff = uieEn && !setMode;

  assign baseUf  = ufFlag  && !clrFlags;
  assign baseAf  = afFlag  && !clrFlags;
  assign baseIrq = irqFlag && !clrFlags;
  assign newUf   = strobe.evalUpdate && !baseUf;
  assign newAf   = strobe.evalUpdate && almMatch && !baseAf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ufFlag  <= 1'b0;
      afFlag  <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      ufFlag  <= baseUf | strobe.evalUpdate;
      afFlag  <= baseAf | (strobe.evalUpdate && almMatch);
      irqFlag <= baseIrq | (newUf && uieEff) | (newAf && aieEn);
    end
  end

  AST_UF_FROM_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ufFlag) |-> $past(strobe.evalUpdate)); // R6

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> (($past(uieEff) && ufFlag) || ($past(aieEn) && afFlag))); // R9

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    $past(clrFlags && !strobe.evalUpdate) |-> (!ufFlag && !afFlag && !irqFlag)); // R10

endmodule

// File: rtl/rtc_update_alarm.sv
module rtc_update_alarm
  import rtc_upd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [2:0] divSel,
  input  logic       setMode,
  input  logic       uieEn,
  input  logic       aieEn,
  input  logic       hour24,
  input  logic       binMode,
  input  logic [7:0] curHour,
  input  logic [7:0] curMin,
  input  logic [7:0] curSec,
  input  logic [7:0] almHour,
  input  logic [7:0] almMin,
  input  logic [7:0] almSec,
  input  logic       clrFlags,
  output logic       incTime,
  output logic       uip,
  output logic       ufFlag,
  output logic       afFlag,
  output logic       irqFlag
);
  updStrobe_t strobe;

  rtc_upd_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .divSel (divSel),
    .setMode(setMode),
    .strobe (strobe),
    .uip    (uip)
  );

  rtc_upd_dpath i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .clrFlags(clrFlags),
    .setMode (setMode),
    .uieEn   (uieEn),
    .aieEn   (aieEn),
    .hour24  (hour24),
    .binMode (binMode),
    .curHour (curHour),
    .curMin  (curMin),
    .curSec  (curSec),
    .almHour (almHour),
    .almMin  (almMin),
    .almSec  (almSec),
    .ufFlag  (ufFlag),
    .afFlag  (afFlag),
    .irqFlag (irqFlag)
  );

  assign incTime = strobe.incTime;

endmodule

// File: tb/test_rtc_update_alarm.sv
module test_rtc_update_alarm;
  localparam int TPS  = 64;
  localparam int UIPT = 8;
  localparam int HALF = TPS / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic tickSlow = 1'b0;
  logic [2:0] divSel = 3'b010;
  logic setMode = 1'b0, uieEn = 1'b1, aieEn = 1'b0, hour24 = 1'b1, binMode = 1'b0;
  logic [7:0] curHour = 8'h12, curMin = 8'h00, curSec = 8'h00;
  logic [7:0] almHour = 8'hC0, almMin = 8'hC0, almSec = 8'hC0;
  logic clrFlags = 1'b0;
  logic incTime, uip, ufFlag, afFlag, irqFlag;

  int checks = 0, failures = 0;
  int cyc = 0, refCyc = 0, events = 0;

  typedef struct {
    int gap; int inc; int uipc;
    bit uf; bit af; bit irq;
    string tag;
  } item_t;
  item_t expQ[$];

  rtc_update_alarm #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) i_rtc_update_alarm (
    .clk(clk), .rstN(rstN), .tick(tick), .divSel(divSel), .setMode(setMode),
    .uieEn(uieEn), .aieEn(aieEn), .hour24(hour24), .binMode(binMode),
    .curHour(curHour), .curMin(curMin), .curSec(curSec),
    .almHour(almHour), .almMin(almMin), .almSec(almSec), .clrFlags(clrFlags),
    .incTime(incTime), .uip(uip), .ufFlag(ufFlag), .afFlag(afFlag), .irqFlag(irqFlag));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // tick pattern
  initial forever begin
    @(negedge clk);
    tick = tickSlow ? ~tick : 1'b1;
  end

  // external time counter model
  function automatic logic [7:0] stepF(input logic [7:0] v, input int lim, output logic wrap);
    int n;
    n = binMode ? int'(v) : int'(v[7:4]) * 10 + int'(v[3:0]);
    n++;
    wrap = (n > lim);
    if (wrap) n = 0;
    return binMode ? 8'(n) : {4'(n / 10), 4'(n % 10)};
  endfunction

  initial forever begin
    logic w;
    @(negedge clk);
    if (rstN && incTime) begin
      curSec = stepF(curSec, 59, w);
      if (w) begin
        curMin = stepF(curMin, 59, w);
        if (w) curHour = stepF(curHour, 23, w);
      end
    end
  end

  // monitor: scoreboard side
  initial begin
    int pend = 0, incCnt = 0, uipCnt = 0;
    bit ufPrev = 1'b0, doCmp;
    item_t it;
    forever begin
      @(negedge clk);
      doCmp = 1'b0;
      if (rstN) begin
        if (uip) uipCnt++;
        if (incTime) incCnt++;
        if (pend > 0) begin
          pend--;
          if (pend == 0) doCmp = 1'b1;
        end else if (incTime) pend = 2;
        else if (ufFlag && !ufPrev) doCmp = 1'b1;
        if (doCmp) begin
          events++;
          if (expQ.size() == 0) begin
            checks++; failures++;
            $display("FAIL R4 unexpected update event actual=1 expected=0");
          end else begin
            it = expQ.pop_front();
            if (it.gap >= 0)  check({it.tag, " gap"}, cyc - refCyc, it.gap);
            check({it.tag, " incTime count"}, incCnt, it.inc);
            if (it.uipc >= 0) check({it.tag, " uip cycles"}, uipCnt, it.uipc);
            check({it.tag, " ufFlag"}, int'(ufFlag), int'(it.uf));
            check({it.tag, " afFlag"}, int'(afFlag), int'(it.af));
            check({it.tag, " irqFlag"}, int'(irqFlag), int'(it.irq));
          end
          refCyc = cyc; incCnt = 0; uipCnt = 0;
        end
      end
      ufPrev = ufFlag;
    end
  end

  // driver side
  task automatic pushExp(int gap, int inc, int uipc, bit uf, bit af, bit irq, string tag);
    item_t it;
    it.gap = gap; it.inc = inc; it.uipc = uipc;
    it.uf = uf; it.af = af; it.irq = irq; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  task automatic clearFlags(string tag);
    clrFlags = 1'b1;
    @(negedge clk);
    clrFlags = 1'b0;
    check({tag, " flags after clear"}, int'({ufFlag, afFlag, irqFlag}), 0);
  endtask

  task automatic setTime(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    curHour = h; curMin = m; curSec = s;
  endtask

  task automatic setAlarm(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    almHour = h; almMin = m; almSec = s;
  endtask

  initial begin
    int seen;
    bit uipHi;
    repeat (5) @(negedge clk);
    check("R1 incTime in reset", int'(incTime), 0);
    check("R1 uip in reset", int'(uip), 0);
    check("R1 flags in reset", int'({ufFlag, afFlag, irqFlag}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", int'({ufFlag, afFlag, irqFlag, incTime}), 0);

    // R7 all wildcards, R9 update interrupt
    pushExp(-1, 1, -1, 1, 1, 1, "R7 R9 first event");
    clearFlags("R10");

    // R6 exact alarm 12:00:05, alarm interrupt only
    setAlarm(8'h12, 8'h00, 8'h05); uieEn = 1'b0; aieEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pushExp(TPS, 1, UIPT, 1, 0, 0, "R2 R3 R6 no match");
      clearFlags("R10");
    end
    pushExp(TPS, 1, UIPT, 1, 1, 1, "R6 match 12:00:05");
    clearFlags("R10");

    // R9 newly set only
    setAlarm(8'hC0, 8'hC0, 8'hC0); aieEn = 1'b0;
    pushExp(TPS, 1, UIPT, 1, 1, 0, "R9 disabled");
    uieEn = 1'b1;
    pushExp(TPS, 1, UIPT, 1, 1, 0, "R9 flag already set");
    clearFlags("R10");
    pushExp(TPS, 1, UIPT, 1, 1, 1, "R9 newly set");
    clearFlags("R10");

    // R7 seconds wildcard, hour/minute exact; R6 minute rollover
    uieEn = 1'b0; aieEn = 1'b1;
    setTime(8'h12, 8'h00, 8'h58); setAlarm(8'h12, 8'h01, 8'hC0);
    pushExp(TPS, 1, UIPT, 1, 0, 0, "R7 12:00:59");
    clearFlags("R10");
    pushExp(TPS, 1, UIPT, 1, 1, 1, "R7 12:01:00");
    clearFlags("R10");
    pushExp(TPS, 1, UIPT, 1, 1, 1, "R7 12:01:01");
    clearFlags("R10");

    // R8 12-hour form with PM bit
    hour24 = 1'b0;
    setTime(8'h81, 8'h00, 8'h59); setAlarm(8'h81, 8'h01, 8'h00);
    pushExp(TPS, 1, UIPT, 1, 1, 1, "R8 1PM match");
    clearFlags("R10");
    setTime(8'h81, 8'h01, 8'h59); setAlarm(8'h01, 8'h02, 8'h00);
    pushExp(TPS, 1, UIPT, 1, 0, 0, "R8 1AM vs 1PM");
    clearFlags("R10");

    // R8 binary mode
    hour24 = 1'b1; binMode = 1'b1;
    setTime(8'd5, 8'd0, 8'd59); setAlarm(8'd5, 8'd1, 8'd0);
    pushExp(TPS, 1, UIPT, 1, 1, 1, "R8 binary match");
    clearFlags("R10");
    binMode = 1'b0;

    // R5 set mode: events, no increment, UIE forced off
    setAlarm(8'hC0, 8'hC0, 8'hC0); aieEn = 1'b0; uieEn = 1'b1; setMode = 1'b1;
    pushExp(-1, 0, 0, 1, 1, 0, "R5 R9 set mode");
    clearFlags("R10");
    pushExp(TPS, 0, 0, 1, 1, 0, "R5 set mode again");
    clearFlags("R10");
    setMode = 1'b0;

    // R5 divider code 011: not running, events continue
    divSel = 3'b011;
    pushExp(TPS, 0, 0, 1, 1, 1, "R5 divider 011");
    clearFlags("R10");

    // R4 divider held
    divSel = 3'b110;
    seen = events; uipHi = 1'b0;
    repeat (3 * TPS) begin
      @(negedge clk);
      if (uip) uipHi = 1'b1;
    end
    check("R4 no events while held", events - seen, 0);
    check("R4 uip while held", int'(uipHi), 0);
    check("R4 flags while held", int'({ufFlag, afFlag, irqFlag}), 0);
    divSel = 3'b010;
    refCyc = cyc;
    pushExp(HALF + 2, 1, UIPT, 1, 1, 1, "R4 half second after release");
    clearFlags("R10");

    // R2 R3 tick gating
    tickSlow = 1'b1;
    pushExp(-1, 1, -1, 1, 1, 1, "R2 switch to slow ticks");
    clearFlags("R10");
    pushExp(2 * TPS, 1, 2 * UIPT, 1, 1, 1, "R2 R3 slow ticks");
    clearFlags("R10");

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

endmodule